// File: doc/BRIEF.md
# Edge-Triggered Capture Timer

This block pairs a free-running up-counter with a single input-capture channel. An external capture pin passes through a synchroniser and an edge detector. When the selected edge appears, the counter's present value is copied into a read-only capture register. A sticky interrupt line can also be raised at that moment. Software controls the block through a small word-addressed read/write bus. It starts and stops the counter, can preload it, chooses which edges trigger a capture, and clears the interrupt.

A typical use is timestamping external events. Software enables the counter and picks rising edges, falling edges or both. It sets the capture and interrupt enables. On each interrupt it reads the latched count and clears the flag. Reads are combinational and return zero when the bus is idle.

Top module: `capture_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is low. The registers are run control at byte offset 0x04, counter at 0x08, match value at 0x18, capture control at 0x28, capture value at 0x2C and interrupt status at 0x34.
- R2: While bit 0 of the run register (0x04) is 1, the counter (0x08, read/write) increases by one per clock and wraps from 0xFFFFFFFF to 0. While that bit is 0 the counter holds its value. A write to 0x08 loads the counter and takes priority over the increment.
- R3: The capture pin goes through a two-flop synchroniser and one more history flop. A pin change made before clock edge N has its capture load and interrupt take effect at edge N+2. The value captured is the counter value held just before that edge.
- R4: The capture control register at 0x28 holds four bits. Bit 0 enables capture on a rising edge (a 0 sample followed by a 1 sample). Bit 1 enables capture on a falling edge (a 1 sample followed by a 0 sample). Bit 2 is the interrupt enable. Bit 3 is the capture function enable. With only one edge bit set, edges of the other polarity load nothing.
- R5: With both edge bits set, every edge of either polarity is a capture event.
- R6: While bit 3 of 0x28 is 0, no edge loads the capture register or raises the interrupt, whatever the other bits hold.
- R7: A capture event sets the interrupt flag only when bit 2 of 0x28 is 1.
- R8: The interrupt flag drives `irq_out` and reads as bit 0 of 0x34. It stays set until a write of 1 to bit 0 of 0x34. When a capture with interrupt enable and a clear fall in the same cycle, the flag ends up set.
- R9: The capture register at 0x2C ignores bus writes. Bits [31:4] of 0x28 always read 0.
- R10: The match register at 0x18 is a 32-bit read/write register that resets to 0.
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when idle |
| cap_pin | input | 1 | Asynchronous capture input |
| irq_out | output | 1 | Sticky capture interrupt |

## Verification
A bus write lands at the rising edge that samples it, and a read returns data in the same cycle. So the bench drives on falling edges and samples one time step later. A pin change reaches the capture register and `irq_out` at the third rising edge after it is applied. The bench therefore checks the interrupt after one, two and three falling edges, and expects it only after the third. A reference model clocked on the same edges pushes the expected counter value into a queue for every capture event. Capture reads pop that queue, and checks against the no-capture cases require it to be empty.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
  // capture control field order: bit3 enable, bit2 irq enable, bit1 fall, bit0 rise
  typedef struct packed {
    logic cap_on;
    logic int_on;
    logic fall_on;
    logic rise_on;
  } cap_ctrl_t;

  localparam int unsigned CTRL_W    = 4;
  localparam logic [7:0]  OFS_RUN   = 8'h04;
  localparam logic [7:0]  OFS_CNT   = 8'h08;
  localparam logic [7:0]  OFS_MATCH = 8'h18;
  localparam logic [7:0]  OFS_CTRL  = 8'h28;
  localparam logic [7:0]  OFS_CAP   = 8'h2C;
  localparam logic [7:0]  OFS_IRQ   = 8'h34;
endpackage

// File: rtl/cap_tmr_edge.sv
module cap_tmr_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              hist_q, hist_d;

  assign sync_d[0] = pin;
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
      assign sync_d[i] = sync_q[i-1];
    end
  endgenerate

  always_comb hist_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~hist_q;
  assign fall = ~sync_q[STAGES-1] & hist_q;
endmodule

// File: rtl/cap_tmr_count.sv
module cap_tmr_count #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld | run;
    cnt_d  = ld ? ld_val : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cap_tmr_latch.sv
module cap_tmr_latch
  import cap_tmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cap_ctrl_t     ctrl,
  input  logic          rise,
  input  logic          fall,
  input  logic [DW-1:0] cnt,
  input  logic          clr,
  output logic [DW-1:0] cap,
  output logic          irq,
  output logic          evt
);
  logic [DW-1:0] cap_q, cap_d;
  logic          irq_q, irq_d;
  logic          irq_set;

  always_comb begin
    evt     = ctrl.cap_on & ((rise & ctrl.rise_on) | (fall & ctrl.fall_on));
    irq_set = evt & ctrl.int_on;
    cap_d   = cnt;
    // a new capture outranks a clear in the same cycle
    if (irq_set)  irq_d = 1'b1;
    else if (clr) irq_d = 1'b0;
    else          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_q <= '0;
    else if (evt) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cap = cap_q;
  assign irq = irq_q;
endmodule

// File: rtl/cap_tmr_regs.sv
module cap_tmr_regs
  import cap_tmr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] cap,
  input  logic          irq,
  output logic          run,
  output cap_ctrl_t     ctrl,
  output logic          cnt_ld,
  output logic          irq_clr
);
  localparam int unsigned   IW      = AW - 2;
  localparam logic [AW-1:0] A_RUN   = AW'(OFS_RUN);
  localparam logic [AW-1:0] A_CNT   = AW'(OFS_CNT);
  localparam logic [AW-1:0] A_MATCH = AW'(OFS_MATCH);
  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_CAP   = AW'(OFS_CAP);
  localparam logic [AW-1:0] A_IRQ   = AW'(OFS_IRQ);
  localparam logic [IW-1:0] W_RUN   = A_RUN[AW-1:2];
  localparam logic [IW-1:0] W_CNT   = A_CNT[AW-1:2];
  localparam logic [IW-1:0] W_MATCH = A_MATCH[AW-1:2];
  localparam logic [IW-1:0] W_CTRL  = A_CTRL[AW-1:2];
  localparam logic [IW-1:0] W_CAP   = A_CAP[AW-1:2];
  localparam logic [IW-1:0] W_IRQ   = A_IRQ[AW-1:2];

  logic [IW-1:0] widx;
  logic          hit, wr;
  logic          run_q, run_d;
  cap_ctrl_t     ctrl_q, ctrl_d;
  logic [DW-1:0] match_q, match_d;
  logic [DW-1:0] rd_mux;

  always_comb begin
    widx = bus_addr[AW-1:2];
    hit  = bus_en & (bus_addr[1:0] == 2'b00);
    wr   = hit & bus_we;
  end

  always_comb begin
    run_d   = run_q;
    ctrl_d  = ctrl_q;
    match_d = match_q;
    if (wr && widx == W_RUN)   run_d   = bus_wdata[0];
    if (wr && widx == W_CTRL)  ctrl_d  = cap_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    if (wr && widx == W_MATCH) match_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ctrl_q  <= '0;
      match_q <= '0;
    end else begin
      run_q   <= run_d;
      ctrl_q  <= ctrl_d;
      match_q <= match_d;
    end
  end

  assign cnt_ld  = wr && (widx == W_CNT);
  assign irq_clr = wr && (widx == W_IRQ) && bus_wdata[0];
  assign run     = run_q;
  assign ctrl    = ctrl_q;

  always_comb begin
    case (widx)
      W_RUN:   rd_mux = {{(DW-1){1'b0}}, run_q};
      W_CNT:   rd_mux = cnt;
      W_MATCH: rd_mux = match_q;
      W_CTRL:  rd_mux = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      W_CAP:   rd_mux = cap;
      W_IRQ:   rd_mux = {{(DW-1){1'b0}}, irq};
      default: rd_mux = '0;
    endcase
    bus_rdata = (hit && !bus_we) ? rd_mux : '0;
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import cap_tmr_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cap_pin,
  output logic          irq_out
);
  logic [1:0]    rs_q, rs_d;
  logic          rst_sync_n;
  logic          run, cnt_ld, irq_clr;
  cap_ctrl_t     ctrl;
  logic [DW-1:0] cnt, cap;
  logic          irq, evt, rise, fall;

  // reset asserts at once, releases two clocks later
  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= rs_d;
  end

  assign rst_sync_n = rs_q[1];

  cap_tmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin(cap_pin), .rise(rise), .fall(fall)
  );

  cap_tmr_count #(.DW(DW)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .ld(cnt_ld),
    .ld_val(bus_wdata), .cnt(cnt)
  );

  cap_tmr_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .ctrl(ctrl), .rise(rise), .fall(fall),
    .cnt(cnt), .clr(irq_clr), .cap(cap), .irq(irq), .evt(evt)
  );

  cap_tmr_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .cap(cap), .irq(irq), .run(run), .ctrl(ctrl),
    .cnt_ld(cnt_ld), .irq_clr(irq_clr)
  );

  assign irq_out = irq;
endmodule

// File: rtl/cap_tmr_chk.sv
module cap_tmr_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cnt_wr,
  input logic          clr_wr,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] cap,
  input logic          irq,
  input logic          evt,
  input logic          cap_on,
  input logic          int_on
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> cnt == $past(cnt) + ONE);

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  a_r6_off_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_on |=> $stable(cap));

  a_r6_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_on && !irq) |=> !irq);

  a_r7_no_ie_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_on && !irq) |=> !irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  a_r8_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && int_on) |=> irq);

  a_r9_load_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cap));
endmodule

bind capture_timer cap_tmr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run), .cnt_wr(cnt_ld),
  .clr_wr(irq_clr), .cnt(cnt), .cap(cap), .irq(irq), .evt(evt),
  .cap_on(ctrl.cap_on), .int_on(ctrl.int_on)
);

// File: tb/sim_capture_timer.sv
module sim_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cap_pin, irq_out;
  int          total = 0;
  int          bad   = 0;
  logic        live  = 1'b0;

  always #10 clk = ~clk;

  capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .irq_out(irq_out)
  );

  // reference model built from the requirements
  logic [31:0] m_cnt, m_cap;
  logic        m_run, m_irq, m_s1, m_s2, m_s3;
  logic [3:0]  m_ctrl;
  logic [31:0] exp_q[$];
  logic        m_wr, m_evt;

  assign m_wr  = bus_en & bus_we;
  assign m_evt = m_ctrl[3] & ((m_s2 & ~m_s3 & m_ctrl[0]) | (~m_s2 & m_s3 & m_ctrl[1]));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cap <= '0; m_run <= 1'b0; m_irq <= 1'b0;
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0; m_ctrl <= '0;
    end else begin
      m_s1 <= cap_pin; m_s2 <= m_s1; m_s3 <= m_s2;
      if (m_wr && bus_addr == 8'h08) m_cnt <= bus_wdata;
      else if (m_run)                m_cnt <= m_cnt + 32'd1;
      if (m_wr && bus_addr == 8'h04) m_run  <= bus_wdata[0];
      if (m_wr && bus_addr == 8'h28) m_ctrl <= bus_wdata[3:0];
      if (m_evt) begin
        m_cap <= m_cnt;
        exp_q.push_back(m_cnt);
      end
      if (m_evt && m_ctrl[2])                           m_irq <= 1'b1;
      else if (m_wr && bus_addr == 8'h34 && bus_wdata[0]) m_irq <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // interrupt line monitor, compared on every falling edge (R7, R8)
  always @(negedge clk) begin
    if (live) chk("R8 irq line vs model", {31'b0, irq_out}, {31'b0, m_irq});
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk);
    cap_pin = v;
  endtask

  // scoreboard pop: compare the capture register with the next expected item
  task automatic cap_pop(input string req);
    logic [31:0] v;
    rd(8'h2C, v);
    if (exp_q.size() == 0) begin
      total++; bad++;
      $display("FAIL %s actual=%h expected=<no capture event>", req, v);
    end else begin
      chk(req, v, exp_q.pop_front());
    end
  endtask

  task automatic no_cap(input string req);
    logic [31:0] v;
    chk(req, exp_q.size(), 32'd0);
    rd(8'h2C, v);
    chk(req, v, m_cap);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; cap_pin = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    live = 1'b1;

    // R1 reset values
    rd(8'h04, v); chk("R1 run reg", v, 0);
    rd(8'h08, v); chk("R1 counter", v, 0);
    rd(8'h18, v); chk("R1 match", v, 0);
    rd(8'h28, v); chk("R1 ctrl", v, 0);
    rd(8'h2C, v); chk("R1 capture", v, 0);
    rd(8'h34, v); chk("R1 irq status", v, 0);
    chk("R1 irq pin", {31'b0, irq_out}, 0);

    // R10 match register
    wr(8'h18, 32'hA5A5_1234); rd(8'h18, v); chk("R10 match readback", v, 32'hA5A5_1234);

    // R11 unmapped offset
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, v); chk("R11 unmapped read", v, 0);

    // R9 ctrl upper bits and read-only capture
    wr(8'h28, 32'hFFFF_FFF0); rd(8'h28, v); chk("R9 ctrl upper bits", v, 0);
    wr(8'h2C, 32'h1234_5678); rd(8'h2C, v); chk("R9 capture write ignored", v, 0);

    // R2 counting, holding, wrap
    wr(8'h08, 32'd100); wr(8'h04, 32'd1); idle(10);
    rd(8'h08, v); chk("R2 counting", v, m_cnt);
    wr(8'h04, 32'd0); rd(8'h08, v); idle(6);
    begin
      logic [31:0] w;
      rd(8'h08, w); chk("R2 hold when stopped", w, v);
    end
    wr(8'h08, 32'hFFFF_FFFE); wr(8'h04, 32'd1); idle(3);
    rd(8'h08, v); chk("R2 wrap", v, m_cnt);
    chk("R2 wrapped past zero", {31'b0, (v < 32'd10)}, 32'd1);

    // R4 rising only
    wr(8'h28, 32'h9);
    pin_set(1'b1); idle(5); cap_pop("R4 rising capture");
    pin_set(1'b0); idle(5); no_cap("R4 falling ignored");

    // R4 falling only
    wr(8'h28, 32'hA);
    pin_set(1'b1); idle(5); no_cap("R4 rising ignored");
    pin_set(1'b0); idle(5); cap_pop("R4 falling capture");

    // R5 both edges
    wr(8'h28, 32'hB);
    pin_set(1'b1); idle(5); cap_pop("R5 both: rising");
    pin_set(1'b0); idle(5); cap_pop("R5 both: falling");
    wr(8'h2C, 32'h0); rd(8'h2C, v); chk("R9 capture write ignored after load", v, m_cap);

    // R6 capture function off
    wr(8'h28, 32'h7);
    pin_set(1'b1); idle(5); no_cap("R6 off rising");
    pin_set(1'b0); idle(5); no_cap("R6 off falling");
    chk("R6 no irq", {31'b0, irq_out}, 0);

    // R7 interrupt enable off then on
    wr(8'h28, 32'h9);
    pin_set(1'b1); idle(5); cap_pop("R7 capture without ie");
    chk("R7 irq stays low", {31'b0, irq_out}, 0);
    pin_set(1'b0);
    wr(8'h28, 32'hD);
    // R3 latency: irq rises at the third edge after the pin change
    pin_set(1'b1);
    idle(1); chk("R3 irq after 1 edge", {31'b0, irq_out}, 0);
    idle(1); chk("R3 irq after 2 edges", {31'b0, irq_out}, 0);
    idle(1); chk("R3 irq after 3 edges", {31'b0, irq_out}, 1);
    cap_pop("R3 captured count");

    // R8 sticky and clear
    idle(8); chk("R8 sticky", {31'b0, irq_out}, 1);
    rd(8'h34, v); chk("R8 status bit", v, 1);
    wr(8'h34, 32'h0); chk("R8 write 0 keeps flag", {31'b0, irq_out}, 1);
    wr(8'h34, 32'h1); chk("R8 cleared", {31'b0, irq_out}, 0);

    // R8 capture and clear in the same cycle: flag stays set
    pin_set(1'b0); idle(5);
    pin_set(1'b1);
    @(negedge clk);
    wr(8'h34, 32'h1);
    chk("R8 capture beats clear", {31'b0, irq_out}, 1);
    cap_pop("R8 capture at clear cycle");
    wr(8'h34, 32'h1);
    chk("R8 clear after race", {31'b0, irq_out}, 0);

    idle(2);
    live = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule